// File: doc/BRIEF.md
# Modular Programmable Clock Divider

This block divides a fast input clock by any integer ratio held in an 11-bit word. The usable range is 3 to 2047. It is built from a cascade of divide-by-2/3 stages. Each stage normally completes its cycle in two input ticks. It stretches that cycle to three ticks when two things are true together: its program bit is one, and the stage above it is asserting its modulus-control line. The modulus-control line travels down the cascade, and the tick enables travel up it.

The number of stages in use depends on the ratio word. It equals the bit position of the word's highest set bit. Stages above that position are held idle, and the highest stage in use treats its modulus-control input as always asserted. This range extension lets short ratios such as 3 to 7 run on one or two stages. Every integer in the range is reachable, with no gaps.

A single-cycle pulse marks the end of each output period; in a synthesizer loop it serves as the feedback clock for the phase comparator. A second strobe marks period completion and is derived from an independent tap of the cascade. A new ratio word is taken only when a period ends, so the period in progress always finishes at the length it started with.

Top module: `modprog_divider`

## Requirements
- R1: With a fixed ratio word N (3 <= N <= 2047), successive rising edges of `pulse_o` are exactly N input clock cycles apart.
- R2: `pulse_o` stays high for exactly one clock cycle per output period.
- R3: `done_o` is high in exactly the cycles in which `pulse_o` is high.
- R4: A ratio word of 0, 1 or 2 divides by 3.
- R5: A ratio word that changes in the middle of a period does not alter that period. The new ratio governs the period that starts after the next pulse.
- R6: After reset is released, the first `pulse_o` is high in the cycle after the N-th rising clock edge, counting the first edge that sees reset low as edge one. N is the ratio word present during reset.
- R7: Reset is synchronous and active high. While it is asserted, both outputs are low from the first reset edge onward. Asserting it in the middle of a period abandons that period, and counting restarts with the ratio word present at release.
- R8: The cascade length follows the most significant set bit of the ratio word. Ratios at each power of two (2^k) and at 2^(k+1)-1, for every chain length from 1 to 10 stages, divide exactly.
- R9: All consecutive ratios from 3 upward divide exactly when the word is stepped by one after each pulse, so no ratio in the range is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 11 | Division ratio word; values below 3 act as 3 |
| pulse_o | output | 1 | One-cycle pulse per output period (registered) |
| done_o | output | 1 | Period-complete strobe from the bottom stage's modulus tap (registered) |

## Verification
The hardest situation to reach is a ratio change landing in a period whose cascade length differs from the new one. In that case some stages have to switch between idle and active at exactly the edge where every active stage wraps. The stimulus steps the ratio word at the cycle right after each pulse. It runs through every value from 3 to 300 and then across each power-of-two boundary up to 2047, so stages join and leave the cascade at every length. A separate test changes the word in the middle of a period and measures that the old length is kept.

// File: rtl/modprog_pkg.sv
package modprog_pkg;

  localparam int unsigned WORD_W    = 11;
  localparam int unsigned MIN_RATIO = 3;

  // Bit position of the highest set bit (0 when the value is zero).
  function automatic int unsigned top_bit(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/mp_cell.sv
// One divide-by-2/3 stage driven by a tick enable from the stage below.
module mp_cell (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ce_i,
  input  logic p_i,
  input  logic mod_i,
  output logic ce_o,
  output logic mod_o
);

  logic [1:0] ph_q;
  logic [1:0] last_c;
  logic       at_last;

  // Swallow one extra tick when programmed and the stage above asks for it.
  assign last_c  = (p_i && mod_i) ? 2'd2 : 2'd1;
  assign at_last = (ph_q == last_c);

  assign ce_o  = en_i & ce_i & at_last;
  assign mod_o = en_i & mod_i & at_last;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      ph_q <= 2'd0;
    end else if (ce_i) begin
      ph_q <= at_last ? 2'd0 : ph_q + 2'd1;
    end
  end

endmodule

// File: rtl/mp_span.sv
// Decodes the active cascade length from the most significant set bit.
module mp_span #(
  parameter int unsigned W     = 11,
  parameter int unsigned CELLS = W - 1,
  parameter int unsigned LW    = $clog2(W)
) (
  input  logic [W-1:0]     word_i,
  output logic [LW-1:0]    len_o,
  output logic [CELLS-1:0] act_o,
  output logic [CELLS-1:0] top_o
);

  assign len_o = LW'(modprog_pkg::top_bit(32'(word_i)));

  for (genvar i = 0; i < CELLS; i++) begin : g_mask
    assign act_o[i] = (LW'(i) < len_o);
    assign top_o[i] = (LW'(i + 1) == len_o);
  end

endmodule

// File: rtl/mp_word.sv
// Holds the ratio of the running period; reloads only at a period end.
module mp_word #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] word_o
);

  localparam logic [W-1:0] FLOOR = W'(modprog_pkg::MIN_RATIO);

  logic [W-1:0] clamped;

  assign clamped = (ratio_i < FLOOR) ? FLOOR : ratio_i;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      word_o <= clamped;
    end
  end

endmodule

// File: rtl/modprog_divider.sv
module modprog_divider #(
  parameter int unsigned W = modprog_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o,
  output logic         done_o
);

  localparam int unsigned CELLS = W - 1;
  localparam int unsigned LW    = $clog2(W);

  logic [W-1:0]     word_q;
  logic [LW-1:0]    len_c;
  logic [CELLS-1:0] act_c;
  logic [CELLS-1:0] top_c;
  logic [CELLS:0]   ce_v;
  logic [CELLS:0]   mod_v;
  logic             end_c;

  mp_word #(.W(W)) u_word (
    .clk     (clk),
    .rst     (rst),
    .load_i  (end_c),
    .ratio_i (ratio_i),
    .word_o  (word_q)
  );

  mp_span #(.W(W), .CELLS(CELLS), .LW(LW)) u_span (
    .word_i (word_q),
    .len_o  (len_c),
    .act_o  (act_c),
    .top_o  (top_c)
  );

  assign ce_v[0]      = 1'b1;
  assign mod_v[CELLS] = 1'b1;

  for (genvar i = 0; i < CELLS; i++) begin : g_stage
    mp_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .en_i  (act_c[i]),
      .ce_i  (ce_v[i]),
      .p_i   (word_q[i]),
      .mod_i (top_c[i] | mod_v[i+1]),
      .ce_o  (ce_v[i+1]),
      .mod_o (mod_v[i])
    );
  end

  // Period ends when the tick leaves the highest active stage.
  assign end_c = ce_v[len_c];

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      pulse_o <= end_c;
      done_o  <= mod_v[0];
    end
  end

endmodule

// File: rtl/modprog_chk.sv
module modprog_chk #(
  parameter int unsigned W = 11
) (
  input logic         clk,
  input logic         rst,
  input logic         pulse_o,
  input logic         done_o,
  input logic [W-1:0] cur_word,
  input logic         period_end
);

  logic [W-1:0] gap_q;
  logic [W-1:0] run_q;

  // Cycles since the last pulse, and the ratio of the period being timed.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (pulse_o) begin
      gap_q <= W'(1);
    end else begin
      gap_q <= gap_q + W'(1);
    end
    if (!rst && gap_q == W'(1)) begin
      run_q <= cur_word;
    end
  end

  p_period_len_r1: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && gap_q != '0) |-> gap_q == run_q);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  p_taps_agree_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_o == done_o);

  p_word_floor_r4: assert property (@(posedge clk) disable iff (rst)
    cur_word >= W'(3));

  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(cur_word));

  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> (!pulse_o && !done_o));

endmodule

bind modprog_divider modprog_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pulse_o    (pulse_o),
  .done_o     (done_o),
  .cur_word   (word_q),
  .period_end (end_c)
);

// File: tb/sim_modprog_divider.sv
`timescale 1ns/1ps
module sim_modprog_divider;

  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ratio = W'(3);
  logic         pulse_o;
  logic         done_o;

  int n_cmp = 0;
  int n_bad = 0;

  modprog_divider #(.W(W)) u0 (
    .clk     (clk),
    .rst     (rst),
    .ratio_i (ratio),
    .pulse_o (pulse_o),
    .done_o  (done_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int w, input int cyc);
    @(negedge clk);
    rst   = 1'b1;
    ratio = W'(w);
    repeat (cyc) @(negedge clk);
    check("R7 pulse low in reset", int'(pulse_o), 0);
    check("R7 done low in reset", int'(done_o), 0);
    rst = 1'b0;
  endtask

  // Counts cycles until pulse_o is seen high at a falling edge.
  task automatic wait_pulse(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (pulse_o || done_o) begin
        check("R3 done matches pulse", int'(done_o), int'(pulse_o));
      end
      if (pulse_o) break;
      if (n > 4200) begin
        check("watchdog: no pulse", n, -1);
        break;
      end
    end
  endtask

  task automatic t_first_pulse();
    int n;
    foreach (lst[k]) begin
      do_reset(lst[k], 3);
      wait_pulse(n);
      check("R6 first pulse delay", n, lst[k]);
      @(negedge clk);
      check("R2 pulse one cycle", int'(pulse_o), 0);
      wait_pulse(n);
      check("R1 steady period", n + 1, lst[k]);
    end
  endtask
  int lst[6] = '{3, 4, 5, 8, 13, 100};

  task automatic t_clamp();
    int n;
    for (int v = 0; v < 3; v++) begin
      do_reset(v, 2);
      wait_pulse(n);
      check("R4 low word first period", n, 3);
      wait_pulse(n);
      check("R4 low word period", n, 3);
    end
  endtask

  // Steps the word after each pulse; the new word applies one period later.
  task automatic t_sweep();
    int n;
    int prev;
    do_reset(3, 2);
    wait_pulse(n);
    check("R9 sweep start", n, 3);
    prev = 3;
    for (int v = 4; v <= 300; v++) begin
      ratio = W'(v);
      wait_pulse(n);
      check("R9 consecutive ratio", n, prev);
      prev = v;
    end
    wait_pulse(n);
    check("R1 sweep last", n, prev);
  endtask

  task automatic t_extend();
    int n;
    int prev;
    do_reset(2047, 2);
    wait_pulse(n);
    check("R8 max ratio first", n, 2047);
    prev = 2047;
    for (int k = 1; k <= 10; k++) begin
      for (int s = 0; s < 2; s++) begin
        int v;
        v = (s == 0) ? (1 << k) : ((1 << (k + 1)) - 1);
        if (v > 2047) v = 2046;
        if (v < 3) v = 3;
        ratio = W'(v);
        wait_pulse(n);
        check("R8 chain length boundary", n, prev);
        prev = v;
      end
    end
    ratio = W'(1025);
    wait_pulse(n);
    check("R8 chain length boundary", n, prev);
    prev = 1025;
    ratio = W'(7);
    wait_pulse(n);
    check("R8 long to short", n, prev);
    wait_pulse(n);
    check("R8 short after long", n, 7);
  endtask

  task automatic t_late_change();
    int n;
    do_reset(40, 2);
    wait_pulse(n);
    check("R6 first pulse 40", n, 40);
    repeat (15) @(negedge clk);
    ratio = W'(9);
    wait_pulse(n);
    check("R5 period kept after change", n + 15, 40);
    wait_pulse(n);
    check("R5 new ratio applied", n, 9);
  endtask

  task automatic t_mid_reset();
    int n;
    do_reset(100, 2);
    repeat (37) @(negedge clk);
    check("R7 no pulse before reset", int'(pulse_o), 0);
    do_reset(6, 2);
    wait_pulse(n);
    check("R7 restart after mid reset", n, 6);
    wait_pulse(n);
    check("R7 period after restart", n, 6);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_first_pulse();
    t_clamp();
    t_late_change();
    t_mid_reset();
    t_extend();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule